// File: doc/BRIEF.md
# Trigger Node Run-State Controller

This block decides whether an event-processing node takes in work. Run-control logic delivers one-cycle command strobes, and the block moves between two operating states. In ACCEPTING, each arriving event strobe goes straight on to a process strobe. In IGNORING, arriving events are discarded, and a saturating counter records how many were lost.

The block also stores the partition number that run control assigns to the node. That number is kept through end-of-run. A halt command can ask for a one-cycle flush pulse so that downstream logic can drop pending work. Every command strobe is answered with an acknowledge pulse on its own bit, one clock later.

There are two states, ST_IGNORE and ST_ACCEPT. These are the transitions:
- ST_IGNORE to ST_ACCEPT on configure or recover.
- ST_ACCEPT to ST_IGNORE on halt or end.
- Every other strobe, and every cycle with no strobe, keeps the current state.

Top module: `node_runstate_ctrl`

## Requirements
- R1: After reset, accept_en is 0 (ST_IGNORE), part_num is 0, flush_pulse is 0, cmd_ack is 0 and drop_count is 0.
- R2: A partition strobe loads part_in into part_num on that clock edge and leaves the operating state unchanged. Without a partition strobe, part_num holds its value.
- R3: A configure or recover strobe puts the block in ST_ACCEPT (accept_en=1) from the next cycle, unless halt or end is also asserted in the same cycle.
- R4: A halt strobe or an end strobe puts the block in ST_IGNORE (accept_en=0) from the next cycle. Halt and end take priority over configure and recover arriving in the same cycle.
- R5: Activate and run strobes change neither accept_en nor part_num.
- R6: An end strobe keeps the stored partition number.
- R7: A halt strobe with flush_req=1 gives flush_pulse=1 for exactly the next cycle. Halt with flush_req=0 gives no flush pulse, and flush_req without halt has no effect.
- R8: The cmd_ack bit order is partition=0, configure=1, activate=2, halt=3, recover=4, run=5, end=6. Each strobe asserted in a cycle sets its own cmd_ack bit for exactly the following cycle.
- R9: evt_process equals evt_in while accept_en is 1 and is 0 while accept_en is 0, in the same cycle.
- R10: An evt_in arriving while accept_en is 0 increments the 16-bit drop_count on that edge. The count saturates at 65535. Events arriving in ST_ACCEPT do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_partition | input | 1 | Store-partition strobe |
| cmd_configure | input | 1 | Configure strobe |
| cmd_activate | input | 1 | Activate strobe |
| cmd_halt | input | 1 | Halt strobe |
| cmd_recover | input | 1 | Recover strobe |
| cmd_run | input | 1 | Run strobe |
| cmd_end | input | 1 | End-of-run strobe |
| part_in | input | PART_W | Partition number supplied with the partition strobe |
| flush_req | input | 1 | Qualifies a halt strobe to request a flush |
| evt_in | input | 1 | Event-arrival strobe |
| accept_en | output | 1 | 1 in ST_ACCEPT |
| part_num | output | PART_W | Stored partition number |
| flush_pulse | output | 1 | One-cycle flush request |
| cmd_ack | output | 7 | Per-command acknowledge, one cycle after the strobe |
| evt_process | output | 1 | Event forwarded for processing |
| drop_count | output | CNT_W | Saturating count of discarded events |

## Verification
A wrong state register appears on accept_en in the cycle after the offending command. It also shows on evt_process immediately: events are forwarded that should be dropped, or dropped that should be forwarded. Because of that, every event sent after the command also gives a wrong drop_count step on the next edge. A corrupted partition or acknowledge path is visible one cycle after the strobe, and it stays visible in part_num until the next partition strobe. The bench checks every output after each stimulated cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/node_rs_pkg.sv
package node_rs_pkg;
    typedef enum logic {
        ST_IGNORE = 1'b0,
        ST_ACCEPT = 1'b1
    } run_state_e;

    localparam int NUM_CMDS  = 7;
    localparam int CMD_PART  = 0;
    localparam int CMD_CONF  = 1;
    localparam int CMD_ACT   = 2;
    localparam int CMD_HALT  = 3;
    localparam int CMD_REC   = 4;
    localparam int CMD_RUN   = 5;
    localparam int CMD_END   = 6;
endpackage

// File: rtl/node_rs_fsm.sv
module node_rs_fsm
    import node_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_accept,
    input  logic go_ignore,
    input  logic halt_flush,
    output logic accept_en,
    output logic flush_pulse
);
    run_state_e state_q, state_d;
    logic       flush_q;

    // next-state selection; ignore-direction commands win
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IGNORE: if (go_accept && !go_ignore) state_d = ST_ACCEPT;
            ST_ACCEPT: if (go_ignore)               state_d = ST_IGNORE;
            default:                                state_d = ST_IGNORE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IGNORE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= halt_flush;
    end

    assign accept_en   = (state_q == ST_ACCEPT);
    assign flush_pulse = flush_q;

    // R4
    ignore_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_ignore |=> !accept_en);
    // R3
    accept_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_accept && !go_ignore) |=> accept_en);
    // R7
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_pulse && !halt_flush) |=> !flush_pulse);
endmodule

// File: rtl/node_rs_ack.sv
module node_rs_ack #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobes,
    output logic [N-1:0] acks
);
    for (genvar i = 0; i < N; i++) begin : g_ack
        always_ff @(posedge clk) begin
            if (!rst_n) acks[i] <= 1'b0;
            else        acks[i] <= strobes[i];
        end
        // R8
        ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            strobes[i] |=> acks[i]);
        // R8
        ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !strobes[i] |=> !acks[i]);
    end
endmodule

// File: rtl/node_rs_drop_ctr.sv
module node_rs_drop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drop_evt,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)                           count <= '0;
        else if (drop_evt && count != CNT_MAX) count <= count + 1'b1;
    end

    // R10
    drop_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX));
    // R10
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_evt |=> $stable(count));
endmodule

// File: rtl/node_runstate_ctrl.sv
module node_runstate_ctrl
    import node_rs_pkg::*;
#(
    parameter int PART_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_partition,
    input  logic              cmd_configure,
    input  logic              cmd_activate,
    input  logic              cmd_halt,
    input  logic              cmd_recover,
    input  logic              cmd_run,
    input  logic              cmd_end,
    input  logic [PART_W-1:0] part_in,
    input  logic              flush_req,
    input  logic              evt_in,
    output logic              accept_en,
    output logic [PART_W-1:0] part_num,
    output logic              flush_pulse,
    output logic [NUM_CMDS-1:0] cmd_ack,
    output logic              evt_process,
    output logic [CNT_W-1:0]  drop_count
);
    logic [NUM_CMDS-1:0] cmd_vec;
    logic [PART_W-1:0]   part_q;

    always_comb begin
        cmd_vec           = '0;
        cmd_vec[CMD_PART] = cmd_partition;
        cmd_vec[CMD_CONF] = cmd_configure;
        cmd_vec[CMD_ACT]  = cmd_activate;
        cmd_vec[CMD_HALT] = cmd_halt;
        cmd_vec[CMD_REC]  = cmd_recover;
        cmd_vec[CMD_RUN]  = cmd_run;
        cmd_vec[CMD_END]  = cmd_end;
    end

    node_rs_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_accept   (cmd_configure | cmd_recover),
        .go_ignore   (cmd_halt | cmd_end),
        .halt_flush  (cmd_halt & flush_req),
        .accept_en   (accept_en),
        .flush_pulse (flush_pulse)
    );

    node_rs_ack #(.N(NUM_CMDS)) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobes (cmd_vec),
        .acks    (cmd_ack)
    );

    node_rs_drop_ctr #(.W(CNT_W)) u_drop (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop_evt (evt_in & ~accept_en),
        .count    (drop_count)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)             part_q <= '0;
        else if (cmd_partition) part_q <= part_in;
    end

    assign part_num    = part_q;
    assign evt_process = evt_in & accept_en;

    // R2
    part_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_partition |=> $stable(part_num));
    // R5
    passive_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_activate || cmd_run) && !cmd_configure && !cmd_recover
         && !cmd_halt && !cmd_end) |=> $stable(accept_en));
    // R6
    end_keeps_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !cmd_partition) |=> $stable(part_num));
endmodule

// File: tb/node_runstate_ctrl_tb.sv
module node_runstate_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] cmds = '0;
    logic [7:0] part_in = '0;
    logic flush_req = 1'b0;
    logic evt_in = 1'b0;
    logic accept_en, flush_pulse, evt_process;
    logic [7:0] part_num;
    logic [6:0] cmd_ack;
    logic [15:0] drop_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    node_runstate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_partition(cmds[0]), .cmd_configure(cmds[1]), .cmd_activate(cmds[2]),
        .cmd_halt(cmds[3]), .cmd_recover(cmds[4]), .cmd_run(cmds[5]), .cmd_end(cmds[6]),
        .part_in(part_in), .flush_req(flush_req), .evt_in(evt_in),
        .accept_en(accept_en), .part_num(part_num), .flush_pulse(flush_pulse),
        .cmd_ack(cmd_ack), .evt_process(evt_process), .drop_count(drop_count)
    );

    typedef struct {
        logic        acc;
        logic [7:0]  part;
        logic        fl;
        logic [6:0]  ack;
        logic [15:0] drops;
        string       req;
    } exp_t;

    exp_t q[$];

    // reference model state
    logic        m_acc = 1'b0;
    logic [7:0]  m_part = '0;
    logic [15:0] m_drops = '0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected results queued
    task automatic step(logic [6:0] c, logic [7:0] p, logic fr, logic ev, string req);
        exp_t e;
        @(negedge clk);
        cmds = c; part_in = p; flush_req = fr; evt_in = ev;
        #1;
        chk("R9", "evt_process", {31'b0, evt_process}, {31'b0, ev & m_acc});
        if (ev && !m_acc && m_drops != 16'hFFFF) m_drops = m_drops + 1'b1;
        if (c[0]) m_part = p;
        if (c[3] || c[6])      m_acc = 1'b0;
        else if (c[1] || c[4]) m_acc = 1'b1;
        e.acc = m_acc; e.part = m_part; e.fl = c[3] & fr; e.ack = c;
        e.drops = m_drops; e.req = req;
        @(posedge clk);
        q.push_back(e);
    endtask

    // monitor: compare after each edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(e.req, "accept_en", {31'b0, accept_en}, {31'b0, e.acc});
            chk(e.req, "part_num", {24'b0, part_num}, {24'b0, e.part});
            chk(e.req, "flush_pulse", {31'b0, flush_pulse}, {31'b0, e.fl});
            chk(e.req, "cmd_ack", {25'b0, cmd_ack}, {25'b0, e.ack});
            chk(e.req, "drop_count", {16'b0, drop_count}, {16'b0, e.drops});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "accept_en", {31'b0, accept_en}, 0);
        chk("R1", "part_num", {24'b0, part_num}, 0);
        chk("R1", "flush_pulse", {31'b0, flush_pulse}, 0);
        chk("R1", "cmd_ack", {25'b0, cmd_ack}, 0);
        chk("R1", "drop_count", {16'b0, drop_count}, 0);
        rst_n = 1'b1;
        step(7'h00, 8'h00, 0, 1, "R10");      // dropped while ignoring
        step(7'h01, 8'hA5, 0, 0, "R2");       // store partition
        step(7'h00, 8'h3C, 0, 0, "R2");       // no strobe: hold
        step(7'h02, 8'h00, 0, 1, "R3");       // configure, event in same cycle dropped
        step(7'h00, 8'h00, 0, 1, "R9");       // processed
        step(7'h04, 8'h00, 0, 1, "R5");       // activate
        step(7'h20, 8'h00, 0, 0, "R5");       // run
        step(7'h08, 8'h00, 1, 0, "R7");       // halt with flush
        step(7'h00, 8'h00, 1, 1, "R7");       // flush_req alone
        step(7'h10, 8'h00, 0, 0, "R3");       // recover
        step(7'h08, 8'h00, 0, 0, "R4");       // halt without flush
        step(7'h12, 8'h00, 0, 0, "R3");       // recover+configure
        step(7'h01, 8'h5A, 0, 1, "R2");       // partition while accepting
        step(7'h40, 8'h00, 0, 0, "R6");       // end keeps partition
        step(7'h02, 8'h00, 0, 0, "R3");
        step(7'h0A, 8'h00, 0, 0, "R4");       // configure+halt -> ignore
        step(7'h50, 8'h00, 0, 0, "R4");       // recover+end -> ignore
        step(7'h7F, 8'h11, 0, 0, "R8");       // all strobes
        step(7'h00, 8'h00, 0, 0, "R8");       // acks drop
        step(7'h40, 8'h00, 0, 0, "R6");
        for (int i = 0; i < 65540; i++) step(7'h00, 8'h00, 0, 1, "R10");
        step(7'h02, 8'h00, 0, 1, "R10");
        step(7'h00, 8'h00, 0, 1, "R10");      // accepted event, count unchanged
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule